// File: doc/BRIEF.md
# NAND Page Hamming Code Accumulator

This block watches the data bus of a NAND memory bank passively, without driving anything. It builds a Hamming parity code over one block of data bytes while the host reads or writes that block. Column parity covers the bit positions inside each byte. Row parity covers the index of each byte within the block. Together they let software correct any single flipped bit and detect any two flipped bits, by comparing the code with one stored earlier. The block length can be chosen from 256 bytes up to 8192 bytes.

A byte counts only when three things are true at once: a read or write strobe is present, the snooped bank is selected, and the access targets the data area. Command cycles and address cycles leave both the code and the byte count untouched. Software sets the enable to start a new block. After the last byte of the block, the finished code appears on the output together with a valid flag. Dropping the enable wipes the code and restarts the count.

A small state machine drives the block. Its states are S_IDLE (disabled, or enabled with no block running yet), S_ACCUM (collecting bytes) and S_DONE (code complete and frozen). Its transitions are named as follows:
- start: S_IDLE→S_ACCUM when the enable is high.
- finish: S_ACCUM→S_DONE on the edge that accepts the final byte.
- abort: S_ACCUM→S_IDLE when the enable drops.
- release: S_DONE→S_IDLE when the enable drops.

Top module: `nand_ecc_acc`

## Requirements
- R1: Out of reset, `code_valid` is 0 and `code_out` is all zeros.
- R2: The block length is 256 shifted left by `len_sel` for `len_sel` values 0 to 5. Values 6 and 7 select 8192. The length is taken while the state is S_IDLE. Later changes to `len_sel` have no effect until the enable is cleared and set again.
- R3: A clock edge accepts data only when all of these hold: (`rd_stb` or `wr_stb`), `bank_act`, `data_area` and `ecc_en`. Every other cycle leaves the code and the byte count unchanged.
- R4: The column code sits in bits 5:0 and is accumulated over the whole block. Bit 0 is the XOR of data bits 0, 2, 4 and 6. Bit 1 covers data bits 1, 3, 5 and 7. Bit 2 covers data bits 0, 1, 4 and 5. Bit 3 covers data bits 2, 3, 6 and 7. Bit 4 covers data bits 3:0. Bit 5 covers data bits 7:4.
- R5: For each byte-index bit k below log2(length), code bit 6+2k holds the XOR of the parities of bytes whose index has bit k equal to 0. Code bit 7+2k holds the same for bytes whose index has bit k equal to 1. All row bits at or above 6+2·log2(length) read 0.
- R6: `code_valid` rises on the clock edge that accepts the final byte of the block, and `code_out` shows the code from that edge on. While `code_valid` is 0, `code_out` reads all zeros.
- R7: Once the block is complete, further accepted strobes change neither the code nor the count until the enable is cleared.
- R8: On the clock edge after `ecc_en` is sampled low, `code_valid` and `code_out` read 0. The next block then begins at byte index 0.
- R9: With a 16-bit bus, each strobe carries two bytes. The low byte takes index n and the high byte takes index n+1.
- R10: Flipping one data bit inside a block changes exactly one bit of each complementary code pair. This holds for the 3 column pairs and for the log2(length) row pairs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| ecc_en | input | 1 | Enable: high starts or continues a block, low clears |
| len_sel | input | 3 | Block length select |
| bank_act | input | 1 | The snooped bank is selected |
| data_area | input | 1 | Access targets the data area, not a command or address location |
| rd_stb | input | 1 | Read strobe, one cycle per transfer |
| wr_stb | input | 1 | Write strobe, one cycle per transfer |
| bus_data | input | DATA_W | Snooped data bus (8 or 16 bits) |
| code_out | output | 32 | Finished code: column bits 5:0, row pairs above them |
| code_valid | output | 1 | Block complete, code readable |

## Verification
Every result is registered exactly once. The edge that accepts the final byte raises `code_valid` and shows the code on that same edge. An edge that samples the enable low clears both outputs. The bench changes inputs on the falling edge and samples outputs on the next falling edge, half a cycle after the edge that produced them. This lets the scoreboard monitor catch the valid flag on its first high sample and compare it with the code the driver queued. The checks that must see no change sample in the cycle right after their stimulus, before any other accepted strobe. These are the checks for strobes after completion and for clearing the enable.

// File: rtl/nand_ecc_pkg.sv
`timescale 1ns/1ps
package nand_ecc_pkg;
    localparam int LOG2_MIN = 8;
    localparam int LOG2_MAX = 13;
    localparam int COL_W    = 6;
    localparam int CODE_W   = COL_W + 2 * LOG2_MAX;
    localparam int LG_W     = $clog2(LOG2_MAX + 1);
    localparam int CNT_W    = LOG2_MAX + 1;
    localparam int SEL_W    = 3;
    localparam int SEL_TOP  = LOG2_MAX - LOG2_MIN;

    typedef enum logic [1:0] {
        S_IDLE  = 2'd0,
        S_ACCUM = 2'd1,
        S_DONE  = 2'd2
    } ecc_state_t;

    // Maps the length select onto log2 of the block length in bytes.
    function automatic logic [LG_W-1:0] sel_to_lg(input logic [SEL_W-1:0] sel);
        if (sel > SEL_W'(SEL_TOP)) begin
            return LG_W'(LOG2_MAX);
        end
        return LG_W'(LOG2_MIN) + LG_W'(sel);
    endfunction
endpackage

// File: rtl/ecc_lane_par.sv
`timescale 1ns/1ps
// Parity contribution of a single byte lane: column parity over its bit
// positions and row parity steered by its index inside the block.
module ecc_lane_par
    import nand_ecc_pkg::*;
(
    input  logic [7:0]          lane_byte,
    input  logic [LOG2_MAX-1:0] byte_idx,
    input  logic [LG_W-1:0]     blk_lg,
    output logic [CODE_W-1:0]   contrib
);
    logic byte_par;

    assign byte_par = ^lane_byte;

    // Column pairs: even/odd bits, pairs of bits, nibbles.
    assign contrib[0] = lane_byte[0] ^ lane_byte[2] ^ lane_byte[4] ^ lane_byte[6];
    assign contrib[1] = lane_byte[1] ^ lane_byte[3] ^ lane_byte[5] ^ lane_byte[7];
    assign contrib[2] = lane_byte[0] ^ lane_byte[1] ^ lane_byte[4] ^ lane_byte[5];
    assign contrib[3] = lane_byte[2] ^ lane_byte[3] ^ lane_byte[6] ^ lane_byte[7];
    assign contrib[4] = ^lane_byte[3:0];
    assign contrib[5] = ^lane_byte[7:4];

    // Row pairs, one per index bit; pairs beyond the block length stay 0.
    for (genvar k = 0; k < LOG2_MAX; k++) begin : g_row
        logic in_blk;
        assign in_blk = (LG_W'(k) < blk_lg);
        assign contrib[COL_W + 2*k]     = in_blk & byte_par & ~byte_idx[k];
        assign contrib[COL_W + 2*k + 1] = in_blk & byte_par &  byte_idx[k];
    end
endmodule

// File: rtl/ecc_seq.sv
`timescale 1ns/1ps
// Block sequencer: length capture, byte counting and the IDLE/ACCUM/DONE FSM.
module ecc_seq
    import nand_ecc_pkg::*;
#(
    parameter int LANES = 1
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                ecc_en,
    input  logic                hit,
    input  logic [SEL_W-1:0]    len_sel,
    output logic                accept,
    output logic [LOG2_MAX-1:0] byte_base,
    output logic [LG_W-1:0]     blk_lg,
    output logic                blk_done,
    output ecc_state_t          state
);
    ecc_state_t       state_q, state_d;
    logic [CNT_W-1:0] cnt_q, cnt_nxt, blk_len;
    logic [LG_W-1:0]  lg_q, lg_eff;
    logic             last_byte;

    always_comb begin
        lg_eff    = (state_q == S_IDLE) ? sel_to_lg(len_sel) : lg_q;
        blk_len   = CNT_W'(1) << lg_eff;
        accept    = ecc_en && (state_q != S_DONE) && hit;
        cnt_nxt   = cnt_q + CNT_W'(LANES);
        last_byte = accept && (cnt_nxt == blk_len);
    end

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_IDLE:  if (ecc_en) state_d = last_byte ? S_DONE : S_ACCUM;   // start
            S_ACCUM: if (!ecc_en) state_d = S_IDLE;                        // abort
                     else if (last_byte) state_d = S_DONE;                  // finish
            S_DONE:  if (!ecc_en) state_d = S_IDLE;                        // release
            default: state_d = S_IDLE;
        endcase
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= S_IDLE;
        else        state_q <= state_d;
    end

    // Count and captured length
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
            lg_q  <= LG_W'(LOG2_MIN);
        end else begin
            if (!ecc_en)     cnt_q <= '0;
            else if (accept) cnt_q <= cnt_nxt;
            if (state_q == S_IDLE) lg_q <= lg_eff;
        end
    end

    // Outputs
    always_comb begin
        blk_done  = (state_q == S_DONE);
        byte_base = cnt_q[LOG2_MAX-1:0];
        blk_lg    = lg_eff;
        state     = state_q;
    end

    a_r2_len_held: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q != S_IDLE) && ecc_en |=> $stable(lg_q));
    a_r3_count_idle_without_hit: assert property (@(posedge clk) disable iff (!rst_n)
        ecc_en && !hit |=> $stable(cnt_q));
    a_r6_done_at_full_count: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_DONE) |-> (cnt_q == (CNT_W'(1) << lg_q)));
    a_r7_done_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_DONE) && ecc_en |=> (state_q == S_DONE) && $stable(cnt_q));
    a_r8_clear_restarts: assert property (@(posedge clk) disable iff (!rst_n)
        !ecc_en |=> (cnt_q == '0) && (state_q == S_IDLE));
endmodule

// File: rtl/nand_ecc_acc.sv
`timescale 1ns/1ps
// Top: snoops data-area strobes and accumulates the Hamming row/column code.
module nand_ecc_acc
    import nand_ecc_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ecc_en,
    input  logic [2:0]        len_sel,
    input  logic              bank_act,
    input  logic              data_area,
    input  logic              rd_stb,
    input  logic              wr_stb,
    input  logic [DATA_W-1:0] bus_data,
    output logic [31:0]       code_out,
    output logic              code_valid
);
    localparam int LANES = DATA_W / 8;

    logic                hit, accept, blk_done;
    logic [LOG2_MAX-1:0] byte_base;
    logic [LG_W-1:0]     blk_lg;
    ecc_state_t          seq_state;
    logic [CODE_W-1:0]   lane_c [LANES];
    logic [CODE_W-1:0]   word_c, code_q;

    assign hit = (rd_stb | wr_stb) & bank_act & data_area;

    ecc_seq #(.LANES(LANES)) u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .ecc_en    (ecc_en),
        .hit       (hit),
        .len_sel   (len_sel),
        .accept    (accept),
        .byte_base (byte_base),
        .blk_lg    (blk_lg),
        .blk_done  (blk_done),
        .state     (seq_state)
    );

    // One parity lane per byte of the bus; lane 0 is the low byte.
    for (genvar l = 0; l < LANES; l++) begin : g_lane
        ecc_lane_par u_par (
            .lane_byte (bus_data[8*l +: 8]),
            .byte_idx  (byte_base + LOG2_MAX'(l)),
            .blk_lg    (blk_lg),
            .contrib   (lane_c[l])
        );
    end

    always_comb begin
        word_c = '0;
        for (int l = 0; l < LANES; l++) word_c ^= lane_c[l];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      code_q <= '0;
        else if (!ecc_en) code_q <= '0;
        else if (accept) code_q <= code_q ^ word_c;
    end

    assign code_valid = blk_done;
    assign code_out   = code_valid ? 32'(code_q) : 32'd0;

    a_r5_upper_rows_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (seq_state != S_IDLE) |-> ((code_q >> (COL_W + 2 * int'(blk_lg))) == '0));
    a_r8_code_cleared: assert property (@(posedge clk) disable iff (!rst_n)
        !ecc_en |=> (code_q == '0) && !code_valid);
    a_r7_code_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        code_valid && ecc_en |=> $stable(code_q));
    a_r3_code_idle_without_hit: assert property (@(posedge clk) disable iff (!rst_n)
        ecc_en && !hit |=> $stable(code_q));
endmodule

// File: tb/tb_nand_ecc_acc.sv
`timescale 1ns/1ps
module tb_nand_ecc_acc;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        en = 1'b0;
    logic [2:0]  len_sel = 3'd0;
    logic        bank = 1'b0, area = 1'b0, rd = 1'b0, wr = 1'b0;
    logic [7:0]  d8 = 8'd0;
    logic [31:0] code;
    logic        valid;

    logic        en16 = 1'b0, stb16 = 1'b0;
    logic [15:0] d16 = 16'd0;
    logic [31:0] code16;
    logic        valid16;

    int n_chk = 0, n_bad = 0;
    logic [31:0] exp_q [$];
    logic [31:0] last_act = '0;
    logic        prev_v = 1'b0;

    always #10 clk = ~clk;

    nand_ecc_acc #(.DATA_W(8)) dut (
        .clk(clk), .rst_n(rst_n), .ecc_en(en), .len_sel(len_sel),
        .bank_act(bank), .data_area(area), .rd_stb(rd), .wr_stb(wr),
        .bus_data(d8), .code_out(code), .code_valid(valid));

    nand_ecc_acc #(.DATA_W(16)) dut16 (
        .clk(clk), .rst_n(rst_n), .ecc_en(en16), .len_sel(3'd0),
        .bank_act(1'b1), .data_area(1'b1), .rd_stb(stb16), .wr_stb(1'b0),
        .bus_data(d16), .code_out(code16), .code_valid(valid16));

    task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [7:0] gen_byte(int seed, int i, int fi, logic [7:0] fm);
        logic [7:0] b;
        b = 8'((i * 37) ^ (i >> 4) ^ seed);
        if (i == fi) b ^= fm;
        return b;
    endfunction

    function automatic int sel_lg(int sel);
        return (sel > 5) ? 13 : 8 + sel;
    endfunction

    // Reference code built from R4 and R5.
    function automatic logic [31:0] model(int lg, int seed, int fi, logic [7:0] fm);
        logic [31:0] c;
        logic [7:0]  b;
        logic        p;
        c = '0;
        for (int i = 0; i < (1 << lg); i++) begin
            b = gen_byte(seed, i, fi, fm);
            p = ^b;
            c[0] ^= b[0] ^ b[2] ^ b[4] ^ b[6];
            c[1] ^= b[1] ^ b[3] ^ b[5] ^ b[7];
            c[2] ^= b[0] ^ b[1] ^ b[4] ^ b[5];
            c[3] ^= b[2] ^ b[3] ^ b[6] ^ b[7];
            c[4] ^= ^b[3:0];
            c[5] ^= ^b[7:4];
            for (int k = 0; k < lg; k++) begin
                if (i[k]) c[7 + 2*k] ^= p;
                else      c[6 + 2*k] ^= p;
            end
        end
        return c;
    endfunction

    task automatic strobe(input logic [7:0] dat, input logic bk, input logic ar, input logic is_wr);
        d8 = dat; bank = bk; area = ar; rd = !is_wr; wr = is_wr;
        @(negedge clk);
        rd = 1'b0; wr = 1'b0;
    endtask

    // Driver: queues the expected code, then plays the block with non-data cycles mixed in.
    task automatic run_block(input int sel, input int seed, input int fi, input logic [7:0] fm, input bit mid_change);
        int n;
        n = 1 << sel_lg(sel);
        exp_q.push_back(model(sel_lg(sel), seed, fi, fm));
        len_sel = 3'(sel);
        en = 1'b1;
        for (int i = 0; i < n; i++) begin
            if (i % 37 == 5) begin
                strobe(8'hA5, 1'b1, 1'b0, 1'b1);   // R3: command/address cycle
                strobe(8'h5A, 1'b0, 1'b1, 1'b0);   // R3: other bank
            end
            if (mid_change && i == 100) len_sel = 3'd0;  // R2: ignored mid-block
            if (i == n - 1)
                check(!valid && code == 32'd0, "R6 not valid before last byte", code, 32'd0);
            strobe(gen_byte(seed, i, fi, fm), 1'b1, 1'b1, 1'(i % 3 == 0));
        end
        check(valid, "R6 valid on last byte edge", 32'(valid), 32'd1);
        @(negedge clk);
    endtask

    // Monitor: compares the code on each rising valid against the queue.
    always @(negedge clk) begin
        if (valid && !prev_v) begin
            if (exp_q.size() == 0) begin
                check(1'b0, "R6 unexpected valid", code, 32'd0);
            end else begin
                logic [31:0] e;
                e = exp_q.pop_front();
                check(code == e, "R4 R5 block code", code, e);
            end
            last_act = code;
        end
        prev_v = valid;
    end

    initial begin
        #(20 * 150000);
        check(1'b0, "watchdog expired", 32'd0, 32'd1);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        logic [31:0] ca, cb, diff, e16;
        bit ok;
        repeat (3) @(negedge clk);
        check(!valid && code == 32'd0, "R1 reset state", code, 32'd0);
        rst_n = 1'b1;
        @(negedge clk);

        // R3: strobes while disabled are ignored
        for (int i = 0; i < 5; i++) strobe(8'hFF, 1'b1, 1'b1, 1'b0);

        run_block(0, 3, -1, 8'h00, 1'b0);
        ca = last_act;
        // R7: extra strobes after completion
        for (int i = 0; i < 4; i++) strobe(8'h81, 1'b1, 1'b1, 1'b1);
        check(valid && code == ca, "R7 code frozen after block", code, ca);
        // R8: clearing the enable
        en = 1'b0;
        @(negedge clk);
        check(!valid && code == 32'd0, "R8 cleared by enable low", code, 32'd0);

        // R10: single flipped bit
        run_block(0, 3, 77, 8'h08, 1'b0);
        cb = last_act;
        diff = ca ^ cb;
        ok = (diff[31:22] == '0);
        for (int j = 0; j < 11; j++) if ($countones(diff[2*j +: 2]) != 1) ok = 1'b0;
        check(ok, "R10 one bit per pair", diff, 32'd0);
        en = 1'b0; @(negedge clk);

        run_block(1, 9, -1, 8'h00, 1'b1);   // R2: 512 with mid-block select change
        en = 1'b0; @(negedge clk);
        run_block(2, 21, -1, 8'h00, 1'b0);  // R2: 1024
        en = 1'b0; @(negedge clk);
        run_block(5, 44, -1, 8'h00, 1'b0);  // R2: 8192
        en = 1'b0; @(negedge clk);
        run_block(7, 60, -1, 8'h00, 1'b0);  // R2: select 7 clamps to 8192
        en = 1'b0; @(negedge clk);
        check(exp_q.size() == 0, "R6 every block completed", 32'(exp_q.size()), 32'd0);

        // R9: 16-bit bus, low byte first
        e16 = model(8, 11, -1, 8'h00);
        en16 = 1'b1;
        for (int w = 0; w < 128; w++) begin
            if (w == 127)
                check(!valid16 && code16 == 32'd0, "R9 not valid before last word", code16, 32'd0);
            d16 = {gen_byte(11, 2*w + 1, -1, 8'h00), gen_byte(11, 2*w, -1, 8'h00)};
            stb16 = 1'b1;
            @(negedge clk);
            stb16 = 1'b0;
        end
        check(valid16 && code16 == e16, "R9 16-bit block code", code16, e16);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule